// File: doc/BRIEF.md
# CSR Access Check and Update Unit

This unit serves control and status register accesses for a core whose register width can be set up to 128 bits. Each request carries a 12-bit register address, the privilege level the hart runs at, a debug-mode flag, a 128-bit write mask and 128-bit write data. In the cycle after a request the unit answers with the register's previous contents, or with an illegal-instruction flag. When the access is legal and the mask is nonzero, it also performs a masked read-modify-write.

The registers held here are a machine scratch register and a supervisor scratch register, each the full register width and stored as two 64-bit halves. There is a status register with a 64-bit write path, a read-only view of the ISA register, and a read-only hart identifier. The status and ISA reads add width-dependent upper bits: the ISA view carries the width code in its two top bits, and the status view carries a dirty-state summary in its top bit. Legality comes from the address itself. Bits [11:10] equal to 3 mark a read-only register, and bits [9:8] give the lowest privilege allowed to touch it.

Top module: `csr_acc_unit`

## Requirements
- R1: A request with `req_valid` high produces exactly one response cycle with `rsp_valid` high on the next clock, and `rsp_valid` stays low when there was no request on the previous clock.
- R2: A request whose address bits [11:10] equal 2'b11 and whose write mask is nonzero is illegal, whether or not `req_debug` is set.
- R3: A request whose `req_priv` is numerically below address bits [9:8] is illegal unless `req_debug` is high, in which case that check is skipped.
- R4: The implemented addresses are 0x300 (status), 0x301 (ISA), 0x340 (machine scratch), 0x140 (supervisor scratch) and 0xF14 (hart identifier). Any other address is illegal.
- R5: A legal response returns the register value held before the access and `rsp_illegal` low. An illegal response has `rsp_illegal` high and `rsp_rdata` zero.
- R6: On a legal access with a nonzero mask, the register becomes (old & ~mask) | (data & mask). With an all-zero mask the register keeps its value.
- R7: Each scratch register holds 128 bits as independent low and high 64-bit halves, and either half can be updated alone by the mask.
- R8: A read of 0x301 returns the `ISA_EXT` bits in [25:0], the width code 3 in [127:126], and zeros elsewhere. Writes to it are accepted as legal and have no effect.
- R9: A read of 0x300 returns the stored 64-bit status in [63:0] and zeros in [126:64]. Bit 127 is 1 exactly when stored bits [14:13] or stored bits [16:15] equal 2'b11.
- R10: After reset, and after every status write, stored status bits [35:34] and [33:32] both equal the width code (3), whatever the write data.
- R11: Registers without a 128-bit write path use only bits [63:0] of mask and data: status bits above 63 never change. The hart identifier reads as `HART_ID` zero-extended to 128 bits.
- R12: An illegal access changes no register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 12 | Register address |
| req_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| req_debug | input | 1 | Debug mode; skips the privilege check |
| req_mask | input | 128 | Write mask, zero for a pure read |
| req_wdata | input | 128 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_illegal | output | 1 | Access rejected as illegal instruction |
| rsp_rdata | output | 128 | Previous register value, zero when illegal |

## Verification
The assertions assume that `req_addr`, `req_priv`, `req_debug` and `req_mask` are known whenever `req_valid` is high. They also assume that one request is answered before the next state comparison, because the unit accepts a request every cycle with no stall. The stimulus drives every input on the falling edge and keeps all of them at defined values, including during reset. It issues requests both back to back and with idle gaps, so the one-cycle response rule and the stable-state checks are exercised under both spacings. Privilege values stay within 0, 1 and 3, so the privilege comparison never meets the reserved encoding.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;

    localparam int DATA_W = 128;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] ADDR_ISA    = 12'h301;
    localparam logic [ADDR_W-1:0] ADDR_MSCR   = 12'h340;
    localparam logic [ADDR_W-1:0] ADDR_SSCR   = 12'h140;
    localparam logic [ADDR_W-1:0] ADDR_HART   = 12'hF14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ISA,
        SEL_MSCR,
        SEL_SSCR,
        SEL_HART
    } csr_sel_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] rdata;
    } csr_rsp_t;

    function automatic csr_sel_e csr_decode(input logic [ADDR_W-1:0] a);
        csr_sel_e s;
        case (a)
            ADDR_STATUS: s = SEL_STATUS;
            ADDR_ISA:    s = SEL_ISA;
            ADDR_MSCR:   s = SEL_MSCR;
            ADDR_SSCR:   s = SEL_SSCR;
            ADDR_HART:   s = SEL_HART;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/csr_acc_check.sv
module csr_acc_check
    import csr_acc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              debug,
    input  logic              wr_req,
    input  csr_sel_e          sel,
    output logic              illegal
);

    logic ro_hit;
    logic priv_hit;
    logic miss_hit;

    always_comb begin
        // R2: top two address bits all ones mark a read-only register
        ro_hit   = (addr[11:10] == 2'b11) && wr_req;
        // R3: the address names the lowest privilege allowed
        priv_hit = !debug && (priv < addr[9:8]);
        // R4: nothing implemented at this address
        miss_hit = (sel == SEL_NONE);
        illegal  = ro_hit || priv_hit || miss_hit;
    end

endmodule

// File: rtl/csr_acc_scratch.sv
module csr_acc_scratch
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] value
);

    localparam int HALF_W = (XLEN > 64) ? 64 : XLEN;
    localparam int N_HALF = (XLEN > 64) ? 2 : 1;

    logic [N_HALF-1:0][HALF_W-1:0] half_d, half_q;

    always_comb begin
        half_d = half_q;
        value  = '0;
        for (int h = 0; h < N_HALF; h++) begin
            if (we) begin
                half_d[h] = (half_q[h] & ~mask[h*HALF_W +: HALF_W])
                          | (data[h*HALF_W +: HALF_W] & mask[h*HALF_W +: HALF_W]);
            end
            value[h*HALF_W +: HALF_W] = half_q[h];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
        end else begin
            half_q <= half_d;
        end
    end

endmodule

// File: rtl/csr_acc_status.sv
module csr_acc_status
    import csr_acc_pkg::*;
#(
    parameter int WIDTH_CODE = 3,
    parameter int XLEN       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [63:0]       mask_lo,
    input  logic [63:0]       data_lo,
    output logic [DATA_W-1:0] rd_view,
    output logic [63:0]       stored
);

    localparam int         ST_W = (XLEN > 64) ? 64 : XLEN;
    localparam logic [1:0] CODE = 2'(WIDTH_CODE);

    logic [ST_W-1:0] stat_d, stat_q;
    logic [ST_W-1:0] merged;
    logic            dirty_sum;

    always_comb begin
        merged = we ? ((stat_q & ~mask_lo[ST_W-1:0]) | (data_lo[ST_W-1:0] & mask_lo[ST_W-1:0]))
                    : stat_q;
    end

    generate
        if (WIDTH_CODE > 1) begin : g_wide
            // R10: the lower-privilege width fields track the configured width
            always_comb begin
                stat_d        = merged;
                stat_d[35:34] = CODE;
                stat_d[33:32] = CODE;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q        <= '0;
                    stat_q[35:34] <= CODE;
                    stat_q[33:32] <= CODE;
                end else begin
                    stat_q <= stat_d;
                end
            end
        end else begin : g_narrow
            always_comb begin
                stat_d = merged;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q <= '0;
                end else begin
                    stat_q <= stat_d;
                end
            end
        end
    endgenerate

    always_comb begin
        // R9: summary of the dirty state fields
        dirty_sum            = (stat_q[14:13] == 2'b11) || (stat_q[16:15] == 2'b11);
        rd_view              = '0;
        rd_view[ST_W-1:0]    = stat_q;
        rd_view[XLEN-1]      = dirty_sum;
        stored               = '0;
        stored[ST_W-1:0]     = stat_q;
    end

endmodule

// File: rtl/csr_acc_unit.sv
module csr_acc_unit
    import csr_acc_pkg::*;
#(
    parameter int          WIDTH_CODE = 3,
    parameter logic [25:0] ISA_EXT    = 26'h014112D,
    parameter logic [63:0] HART_ID    = 64'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_priv,
    input  logic                req_debug,
    input  logic [DATA_W-1:0]   req_mask,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic                rsp_illegal,
    output logic [DATA_W-1:0]   rsp_rdata
);

    localparam int                XLEN  = 16 << WIDTH_CODE;
    localparam logic [DATA_W-1:0] XMASK = (XLEN >= DATA_W) ? {DATA_W{1'b1}}
                                                           : ((DATA_W'(1) << XLEN) - DATA_W'(1));
    localparam logic [1:0]        CODE  = 2'(WIDTH_CODE);

    csr_sel_e          sel;
    logic [DATA_W-1:0] mask_eff;
    logic              wr_req;
    logic              illegal;
    logic              do_write;
    logic              we_status, we_mscr, we_sscr;
    logic [DATA_W-1:0] mscr_val, sscr_val, status_rd;
    logic [63:0]       status_val;
    logic [DATA_W-1:0] isa_rd, hart_rd, old_val;
    csr_rsp_t          rsp_d, rsp_q;

    csr_acc_check u_check (
        .addr    (req_addr),
        .priv    (req_priv),
        .debug   (req_debug),
        .wr_req  (wr_req),
        .sel     (sel),
        .illegal (illegal)
    );

    csr_acc_scratch #(.XLEN(XLEN)) u_mscr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_mscr),
        .mask  (mask_eff),
        .data  (req_wdata),
        .value (mscr_val)
    );

    csr_acc_scratch #(.XLEN(XLEN)) u_sscr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_sscr),
        .mask  (mask_eff),
        .data  (req_wdata),
        .value (sscr_val)
    );

    csr_acc_status #(.WIDTH_CODE(WIDTH_CODE), .XLEN(XLEN)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we_status),
        .mask_lo (mask_eff[63:0]),
        .data_lo (req_wdata[63:0]),
        .rd_view (status_rd),
        .stored  (status_val)
    );

    always_comb begin
        sel      = csr_decode(req_addr);
        mask_eff = req_mask & XMASK;
        // R11: the status path only ever sees the low 64 mask bits
        wr_req   = (sel == SEL_STATUS) ? (|mask_eff[63:0]) : (|mask_eff);
        do_write = req_valid && !illegal && wr_req;

        we_status = do_write && (sel == SEL_STATUS);
        we_mscr   = do_write && (sel == SEL_MSCR);
        we_sscr   = do_write && (sel == SEL_SSCR);

        // R8: ISA view carries the width code in its top two bits
        isa_rd                = '0;
        isa_rd[25:0]          = ISA_EXT;
        isa_rd[XLEN-1 -: 2]   = CODE;

        hart_rd               = {64'h0, HART_ID} & XMASK;

        case (sel)
            SEL_STATUS: old_val = status_rd;
            SEL_ISA:    old_val = isa_rd;
            SEL_MSCR:   old_val = mscr_val;
            SEL_SSCR:   old_val = sscr_val;
            SEL_HART:   old_val = hart_rd;
            default:    old_val = '0;
        endcase

        rsp_d.valid   = req_valid;
        rsp_d.illegal = req_valid && illegal;
        rsp_d.rdata   = (req_valid && !illegal) ? old_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_illegal = rsp_q.illegal;
    assign rsp_rdata   = rsp_q.rdata;

endmodule

// File: rtl/csr_acc_sva.sv
module csr_acc_sva
    import csr_acc_pkg::*;
#(
    parameter int WIDTH_CODE = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [1:0]          req_priv,
    input logic                req_debug,
    input logic [DATA_W-1:0]   req_mask,
    input logic                rsp_valid,
    input logic                rsp_illegal,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [DATA_W-1:0]   mscr_val,
    input logic [DATA_W-1:0]   sscr_val,
    input logic [63:0]         status_val
);

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_ro_write_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:10] == 2'b11 && req_mask != '0) |=> rsp_illegal);

    assert_low_priv_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_debug && req_priv < req_addr[9:8]) |=> rsp_illegal);

    assert_illegal_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_valid && rsp_rdata == '0));

    assert_zero_mask_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mask == '0) |=>
            ($stable(mscr_val) && $stable(sscr_val) && $stable(status_val)));

    assert_illegal_keeps_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |->
            ($stable(mscr_val) && $stable(sscr_val) && $stable(status_val)));

    generate
        if (WIDTH_CODE > 1) begin : g_xl
            assert_width_fields_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
                status_val[35:32] == {2'(WIDTH_CODE), 2'(WIDTH_CODE)});
        end
    endgenerate

endmodule

bind csr_acc_unit csr_acc_sva #(.WIDTH_CODE(WIDTH_CODE)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_priv    (req_priv),
    .req_debug   (req_debug),
    .req_mask    (req_mask),
    .rsp_valid   (rsp_valid),
    .rsp_illegal (rsp_illegal),
    .rsp_rdata   (rsp_rdata),
    .mscr_val    (mscr_val),
    .sscr_val    (sscr_val),
    .status_val  (status_val)
);

// File: tb/tb_csr_acc_unit.sv
module tb_csr_acc_unit;

    localparam int          CLK_PERIOD = 10;
    localparam logic [25:0] EXT        = 26'h014112D;
    localparam logic [63:0] HID        = 64'h0000_0000_0000_0005;
    localparam logic [127:0] ONES      = {128{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [1:0]   req_priv = '0;
    logic         req_debug = 1'b0;
    logic [127:0] req_mask = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_illegal;
    logic [127:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic         ill;
        logic [127:0] rd;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    // reference model state, built from the requirements
    logic [127:0] m_mscr = '0;
    logic [127:0] m_sscr = '0;
    logic [63:0]  m_stat = 64'h0000_000F_0000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_acc_unit #(.WIDTH_CODE(3), .ISA_EXT(EXT), .HART_ID(HID)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_priv    (req_priv),
        .req_debug   (req_debug),
        .req_mask    (req_mask),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_illegal (rsp_illegal),
        .rsp_rdata   (rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] status_view(input logic [63:0] st);
        logic [127:0] v;
        v        = {64'h0, st};
        v[127]   = (st[14:13] == 2'b11) || (st[16:15] == 2'b11);
        return v;
    endfunction

    // driver: model the access, push the expected response, drive the pins
    task automatic access(input logic [11:0] a, input logic [1:0] p, input logic dbg,
                          input logic [127:0] m, input logic [127:0] d, input string tag);
        exp_t e;
        logic known, ill, wr;
        logic [127:0] old;
        known = (a == 12'h300) || (a == 12'h301) || (a == 12'h340) ||
                (a == 12'h140) || (a == 12'hF14);
        wr    = (a == 12'h300) ? (m[63:0] != '0) : (m != '0);
        ill   = !known || ((a[11:10] == 2'b11) && wr) || (!dbg && (p < a[9:8]));
        case (a)
            12'h300: old = status_view(m_stat);
            12'h301: begin old = '0; old[25:0] = EXT; old[127:126] = 2'b11; end
            12'h340: old = m_mscr;
            12'h140: old = m_sscr;
            12'hF14: old = {64'h0, HID};
            default: old = '0;
        endcase
        if (!ill && wr) begin
            case (a)
                12'h340: m_mscr = (m_mscr & ~m) | (d & m);
                12'h140: m_sscr = (m_sscr & ~m) | (d & m);
                12'h300: begin
                    m_stat = (m_stat & ~m[63:0]) | (d[63:0] & m[63:0]);
                    m_stat[35:32] = 4'hF;
                end
                default: ;
            endcase
        end
        e.ill = ill;
        e.rd  = ill ? '0 : old;
        e.tag = tag;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_priv  = p;
        req_debug = dbg;
        req_mask  = m;
        req_wdata = d;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_mask  = '0;
        end
    endtask

    // monitor: pop and compare each response as it appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected response", {127'h0, rsp_valid}, 128'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_illegal === e.ill, {e.tag, " illegal flag"}, {127'h0, rsp_illegal}, {127'h0, e.ill});
                check(rsp_rdata === e.rd, {e.tag, " read data"}, rsp_rdata, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1 no response in reset", {127'h0, rsp_valid}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R1 idle after reset", {127'h0, rsp_valid}, 128'h0);

        // R10 R9: reset status with forced width fields, summary clear
        access(12'h300, 2'd3, 1'b0, '0, '0, "R10 reset status");
        // R6 R7: full-width scratch write returns old zero
        access(12'h340, 2'd3, 1'b0, ONES, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEED_F00D, "R7 mscratch full write");
        access(12'h340, 2'd3, 1'b0, '0, ONES, "R5 mscratch read back");
        // R7: high half only
        access(12'h340, 2'd3, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, "R7 high half write");
        access(12'h340, 2'd3, 1'b0, '0, '0, "R7 high half result");
        // R6: partial bit mask
        access(12'h340, 2'd3, 1'b0, 128'h0000_00FF_0000_0000_0000_0000_F0F0_0000, '0, "R6 partial mask clear");
        access(12'h340, 2'd3, 1'b0, '0, '0, "R6 partial mask result");
        idle(2);
        check(rsp_valid === 1'b0, "R1 no response after gap", {127'h0, rsp_valid}, 128'h0);

        // R3: supervisor scratch from supervisor, user, user in debug
        access(12'h140, 2'd1, 1'b0, ONES, 128'hA5A5_0000_0000_0000_0000_0000_0000_5A5A, "R3 sscratch from supervisor");
        access(12'h140, 2'd0, 1'b0, ONES, 128'h0, "R3 sscratch from user");
        access(12'h140, 2'd0, 1'b1, '0, '0, "R3 sscratch user debug read");
        access(12'h340, 2'd1, 1'b0, ONES, '0, "R3 mscratch from supervisor");
        access(12'h340, 2'd3, 1'b0, '0, '0, "R12 mscratch unchanged");
        access(12'h140, 2'd3, 1'b0, '0, '0, "R12 sscratch unchanged");

        // R2 R11: hart identifier
        access(12'hF14, 2'd3, 1'b0, '0, '0, "R11 hart id zero-extended");
        access(12'hF14, 2'd3, 1'b0, 128'h1, 128'h1, "R2 hart id write");
        access(12'hF14, 2'd3, 1'b1, 128'h1, 128'h1, "R2 hart id write in debug");

        // R4: unknown addresses
        access(12'h7C0, 2'd3, 1'b0, '0, '0, "R4 unknown address 7C0");
        access(12'h341, 2'd3, 1'b1, '0, '0, "R4 unknown address 341");

        // R8: ISA view and ignored write
        access(12'h301, 2'd3, 1'b0, ONES, '0, "R8 ISA write");
        access(12'h301, 2'd3, 1'b0, '0, '0, "R8 ISA unchanged");
        idle(1);

        // R9 R10 R11: status write with upper data and cleared width fields
        access(12'h300, 2'd3, 1'b0, ONES, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_6000}, "R11 status full write");
        access(12'h300, 2'd3, 1'b0, '0, '0, "R9 status summary from [14:13]");
        access(12'h300, 2'd3, 1'b0, 128'h1_E000, 128'h1_8000, "R9 status move dirty field");
        access(12'h300, 2'd3, 1'b0, '0, '0, "R9 status summary from [16:15]");
        access(12'h300, 2'd3, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, ONES, "R11 status upper-only mask");
        access(12'h300, 2'd3, 1'b0, 128'h1_8000, '0, "R9 status clear dirty");
        access(12'h300, 2'd1, 1'b0, ONES, '0, "R12 status from supervisor");
        access(12'h300, 2'd3, 1'b0, '0, '0, "R10 status final");
        idle(3);
        check(sb_q.size() == 0, "R1 all responses seen", 128'(sb_q.size()), 128'h0);
        check(rsp_valid === 1'b0, "R1 quiet at end", {127'h0, rsp_valid}, 128'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule